// File: doc/BRIEF.md
# Two-Wire Slave with Register Pointer

This block is a slave on an SMBus / I2C-style two-wire bus that opens an 8-bit register file to a bus master. The bus clock and data lines are brought into the system clock domain, oversampled and edge-detected. The block does not drive the wire directly. It has one output that asks an external open-drain cell to pull the data line low.

A master addresses the slave with a 7-bit address. The upper five bits form a prefix that software can reprogram at run time. The lower two bits come from two strap pins, which are captured while reset is held. In a write transaction, the first byte sets an internal pointer and an optional second byte writes the register that the pointer selects. In a read transaction, the slave returns one byte from the register that the pointer selects. The pointer is presented continuously on the register-file address port, and the register file answers combinationally on the read-data port.

Top module: `smb_ptr_slave`

## Requirements
- R1: While and just after synchronous reset, the pull-down output is inactive, the write strobe is low and the register address output is 0x00.
- R2: After reset, the slave address is {5'b01011, strap[1:0]}, with the strap captured during reset. The slave pulls data low for the ninth clock of an address byte that matches this address, with the R/W bit as the eighth bit (0 = write, 1 = read, MSB first).
- R3: If an address byte does not match, the slave does not acknowledge it. The slave also ignores every following byte until the next START: no acknowledge, no write strobe and no change to the pointer.
- R4: In a write transaction, the first byte after the address is loaded into the pointer, which appears on the register address output. A transaction that carries only this byte causes no write strobe.
- R5: The second byte of a write transaction produces exactly one single-cycle write strobe. The strobe carries that byte on the write-data output and the pointer on the address output, and the pointer is held stable during the strobe.
- R6: A read transaction shifts out, MSB first, the byte that the register file returns for the current pointer. The slave releases the data line for the master's acknowledge clock.
- R7: Bytes after the second byte of a write transaction are acknowledged but neither written nor loaded into the pointer.
- R8: A data write whose pointer equals 0x48 replaces the address prefix with bits 6:2 of the data byte. From the next START, the old address is no longer acknowledged.
- R9: The two low address bits cannot be changed by the prefix write (bits 1:0 of the data byte are ignored) or by strap pin changes after reset.
- R10: A repeated START (a START with no STOP before it) begins a new address phase. A pointer written before it is used by a following read.
- R11: A STOP releases the data line and returns the slave to idle.
- R12: The slave changes its pull-down only while the bus clock is low.
- R13: A reset restores the default prefix, clears the pointer and re-captures the strap pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset; strap pins captured while high |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Hardwired low address bits |
| sda_pd_o | output | 1 | 1 asks the open-drain cell to pull data low |
| reg_addr_o | output | 8 | Register pointer to the register file |
| reg_wdata_o | output | 8 | Write data to the register file |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_rdata_i | input | 8 | Register file read data for reg_addr_o |

## Verification
The bench targets the points where a slave of this kind most often goes wrong. Extra write bytes are sent: a slave that kept writing would issue a second strobe, which the scoreboard flags as unexpected. The address is reprogrammed with data whose low bits differ from the straps, so a slave that let those bits through would answer the wrong address. A repeated START is placed between a pointer write and a read; a slave that waited for STOP would leave the read unacknowledged. Mismatched addresses are followed by full data bytes, and the reset test changes the straps first, so a slave that still answers the old address, or that captured the pins only once, misses an expected acknowledge or acknowledges when it should not.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;

    localparam int BYTE_W   = 8;
    localparam int PIN_W    = 2;
    localparam int PREFIX_W = 5;
    localparam int SA_W     = PREFIX_W + PIN_W;
    localparam int BIT_CW   = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_RX,
        ST_ACK_RX,
        ST_TX
    } smb_state_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef enum logic [1:0] {
        BYTE_PTR  = 2'd0,
        BYTE_DATA = 2'd1,
        BYTE_XTRA = 2'd2
    } byte_slot_e;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [SA_W-1:0] own);
        return b[BYTE_W-1:1] == own;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_ptr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_lvl_o,
    output bus_ev_t ev_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '1;
            else     q <= {q[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= lvl;
    end

    logic scl_now, sda_now, scl_was, sda_was;
    assign scl_now = lvl[1];
    assign sda_now = lvl[0];
    assign scl_was = prev[1];
    assign sda_was = prev[0];

    always_comb begin
        ev_o.sda      = sda_now;
        ev_o.scl_rise = scl_now & ~scl_was;
        ev_o.scl_fall = ~scl_now & scl_was;
        ev_o.start    = scl_now & scl_was & sda_was & ~sda_now;
        ev_o.stop     = scl_now & scl_was & ~sda_was & sda_now;
    end

    assign scl_lvl_o = scl_now;

endmodule

// File: rtl/smb_addr_reg.sv
module smb_addr_reg
    import smb_ptr_pkg::*;
#(
    parameter logic [PREFIX_W-1:0] PREFIX_RST = 5'b01011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIN_W-1:0]  pins_i,
    input  logic              upd_i,
    input  logic [BYTE_W-1:0] upd_data_i,
    output logic [SA_W-1:0]   own_o
);
    logic [PIN_W-1:0]    pins_q;
    logic [PREFIX_W-1:0] prefix_q;

    always_ff @(posedge clk) begin
        if (rst) pins_q <= pins_i;
    end

    always_ff @(posedge clk) begin
        if (rst)        prefix_q <= PREFIX_RST;
        else if (upd_i) prefix_q <= upd_data_i[SA_W-1:PIN_W];
    end

    assign own_o = {prefix_q, pins_q};

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
    import smb_ptr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ADDR_REG_IDX = 8'h48
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev_i,
    input  logic [SA_W-1:0]   own_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              sda_pd_o,
    output logic [BYTE_W-1:0] ptr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              we_o,
    output logic              upd_o
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    smb_state_e        state;
    logic [BYTE_W-1:0] sh;
    logic [BIT_CW-1:0] cnt;
    logic              got_byte;
    logic              rw;
    byte_slot_e        slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sh       <= '0;
            cnt      <= '0;
            got_byte <= 1'b0;
            rw       <= 1'b0;
            slot     <= BYTE_PTR;
            sda_pd_o <= 1'b0;
            ptr_o    <= '0;
            wdata_o  <= '0;
            we_o     <= 1'b0;
            upd_o    <= 1'b0;
        end else begin
            we_o  <= 1'b0;
            upd_o <= 1'b0;
            if (ev_i.start) begin
                state    <= ST_ADDR;
                cnt      <= '0;
                got_byte <= 1'b0;
                sda_pd_o <= 1'b0;
            end else if (ev_i.stop) begin
                state    <= ST_IDLE;
                sda_pd_o <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_RX: begin
                        if (ev_i.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], ev_i.sda};
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) got_byte <= 1'b1;
                        end else if (ev_i.scl_fall && got_byte) begin
                            got_byte <= 1'b0;
                            if (state == ST_ADDR) begin
                                if (addr_hit(sh, own_i)) begin
                                    sda_pd_o <= 1'b1;
                                    rw       <= sh[0];
                                    state    <= ST_ACK_ADDR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_pd_o <= 1'b1;
                                state    <= ST_ACK_RX;
                                unique case (slot)
                                    BYTE_PTR: begin
                                        ptr_o <= sh;
                                        slot  <= BYTE_DATA;
                                    end
                                    BYTE_DATA: begin
                                        we_o    <= 1'b1;
                                        wdata_o <= sh;
                                        upd_o   <= (ptr_o == ADDR_REG_IDX);
                                        slot    <= BYTE_XTRA;
                                    end
                                    default: slot <= BYTE_XTRA;
                                endcase
                            end
                        end
                    end
                    ST_ACK_ADDR: begin
                        if (ev_i.scl_fall) begin
                            cnt  <= '0;
                            slot <= BYTE_PTR;
                            if (rw) begin
                                sh       <= rdata_i;
                                sda_pd_o <= ~rdata_i[BYTE_W-1];
                                state    <= ST_TX;
                            end else begin
                                sda_pd_o <= 1'b0;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_ACK_RX: begin
                        if (ev_i.scl_fall) begin
                            sda_pd_o <= 1'b0;
                            cnt      <= '0;
                            state    <= ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (ev_i.scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                sda_pd_o <= 1'b0;
                                state    <= ST_IDLE;
                            end else begin
                                sh       <= {sh[BYTE_W-2:0], 1'b0};
                                sda_pd_o <= ~sh[BYTE_W-2];
                                cnt      <= cnt + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
    import smb_ptr_pkg::*;
#(
    parameter int                    SYNC_STAGES  = 2,
    parameter logic [PREFIX_W-1:0]   PREFIX_RST   = 5'b01011,
    parameter logic [BYTE_W-1:0]     ADDR_REG_IDX = 8'h48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [PIN_W-1:0]  strap_i,
    output logic              sda_pd_o,
    output logic [BYTE_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);
    bus_ev_t           bus_ev;
    logic              scl_lvl;
    logic [SA_W-1:0]   own_addr;
    logic              prefix_upd;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl_o (scl_lvl),
        .ev_o      (bus_ev)
    );

    smb_addr_reg #(.PREFIX_RST(PREFIX_RST)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .pins_i     (strap_i),
        .upd_i      (prefix_upd),
        .upd_data_i (reg_wdata_o),
        .own_o      (own_addr)
    );

    smb_ctrl #(.ADDR_REG_IDX(ADDR_REG_IDX)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ev_i     (bus_ev),
        .own_i    (own_addr),
        .rdata_i  (reg_rdata_i),
        .sda_pd_o (sda_pd_o),
        .ptr_o    (reg_addr_o),
        .wdata_o  (reg_wdata_o),
        .we_o     (reg_we_o),
        .upd_o    (prefix_upd)
    );

endmodule

// File: rtl/smb_ptr_slave_chk.sv
module smb_ptr_slave_chk
    import smb_ptr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_s,
    input logic              ev_start,
    input logic              ev_stop,
    input logic              sda_pd_o,
    input logic              reg_we_o,
    input logic [BYTE_W-1:0] reg_addr_o,
    input logic [SA_W-1:0]   own_addr
);
    // R12: pull-down moves only after SCL was seen low
    p_pd_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_pd_o) && !$past(ev_start) && !$past(ev_stop)) |-> !$past(scl_s));

    // R5: strobe lasts one cycle
    p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |=> !reg_we_o);

    // R5: pointer steady while strobing
    p_ptr_steady_r5: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |-> $stable(reg_addr_o));

    // R11: STOP frees the line
    p_stop_release_r11: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> !sda_pd_o);

    // R9: strap bits never move outside reset
    p_pins_locked_r9: assert property (@(posedge clk) disable iff (rst)
        $stable(own_addr[PIN_W-1:0]));
endmodule

bind smb_ptr_slave smb_ptr_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (scl_lvl),
    .ev_start   (bus_ev.start),
    .ev_stop    (bus_ev.stop),
    .sda_pd_o   (sda_pd_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o),
    .own_addr   (own_addr)
);

// File: tb/smb_ptr_slave_bench.sv
module smb_ptr_slave_bench;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       sda_pd;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we;
    logic       sda_line;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];

    typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_item_t;
    wr_item_t exp_q [$];

    int n_chk = 0, n_fail = 0, pd_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign sda_line  = sda_m & ~sda_pd;
    assign reg_rdata = mem[reg_addr];

    smb_ptr_slave u_smb_ptr_slave (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
        .sda_pd_o(sda_pd), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
        .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every write strobe must match a queued item
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3/R7 unexpected write", {16'h0, reg_addr, reg_wdata}, 32'h0);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk({reg_addr, reg_wdata} == it, "R5 write item", {reg_addr, reg_wdata}, it);
            end
            mem[reg_addr] = reg_wdata;
        end
    end

    // R12 at the ports
    always @(sda_pd) if (!rst && scl) pd_bad++;

    task automatic wq; repeat (Q) @(negedge clk); endtask
    task automatic b_start; sda_m = 1; wq; scl = 1; wq; sda_m = 0; wq; scl = 0; wq; endtask
    task automatic b_stop;  sda_m = 0; wq; scl = 1; wq; sda_m = 1; wq; endtask
    task automatic put_bit(input logic b); sda_m = b; wq; scl = 1; wq; wq; scl = 0; wq; endtask
    task automatic get_bit(output logic b); sda_m = 1; wq; scl = 1; wq; b = sda_line; wq; scl = 0; wq; endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(x);
        ack = !x;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) get_bit(b[i]);
        put_bit(1'b1);
    endtask

    task automatic t_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                           input bit exp_ack, input string req);
        logic ack;
        if (exp_ack) begin
            exp_q.push_back({p, d});
            exp_mem[p] = d;
        end
        b_start;
        wr_byte({a, 1'b0}, ack); chk(ack == exp_ack, req, ack, exp_ack);
        wr_byte(p, ack);         chk(ack == exp_ack, req, ack, exp_ack);
        wr_byte(d, ack);         chk(ack == exp_ack, req, ack, exp_ack);
        b_stop;
    endtask

    task automatic t_ptr(input logic [6:0] a, input logic [7:0] p);
        logic ack;
        b_start;
        wr_byte({a, 1'b0}, ack); chk(ack, "R2 ptr addr ack", ack, 1);
        wr_byte(p, ack);         chk(ack, "R4 ptr byte ack", ack, 1);
        b_stop;
        chk(reg_addr == p, "R4 pointer on port", reg_addr, p);
    endtask

    task automatic t_read(input logic [6:0] a, input logic [7:0] exp, input string req);
        logic ack; logic [7:0] v;
        b_start;
        wr_byte({a, 1'b1}, ack); chk(ack, "R2 read addr ack", ack, 1);
        rd_byte(v);              chk(v == exp, req, v, exp);
        b_stop;
    endtask

    task automatic t_probe(input logic [6:0] a, input bit exp_ack, input string req);
        logic ack;
        b_start;
        wr_byte({a, 1'b0}, ack); chk(ack == exp_ack, req, ack, exp_ack);
        b_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack; logic [7:0] v;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 3) ^ 8'hA5;
            exp_mem[i] = mem[i];
        end
        repeat (5) @(negedge clk);
        // R1 during reset
        chk(sda_pd == 0 && reg_we == 0, "R1 reset outputs", {sda_pd, reg_we}, 0);
        rst = 0;
        wq;
        chk(reg_addr == 8'h00, "R1 pointer after reset", reg_addr, 0);
        chk(sda_pd == 0, "R1 line released", sda_pd, 0);

        // R2, R5: default address 0x2E (01011 + strap 10)
        t_write(7'h2E, 8'h10, 8'hC3, 1, "R5 write acks");
        // R6
        t_read(7'h2E, exp_mem[8'h10], "R6 read data 0x10");
        // R4
        t_ptr(7'h2E, 8'h20);
        t_read(7'h2E, exp_mem[8'h20], "R6 read data 0x20");

        // R3: mismatching addresses, data bytes ignored
        t_write(7'h2F, 8'h55, 8'h66, 0, "R3 no ack wrong low bit");
        t_write(7'h6E, 8'h55, 8'h66, 0, "R3 no ack wrong prefix");
        chk(reg_addr == 8'h20, "R3 pointer untouched", reg_addr, 8'h20);

        // R7: extra bytes acked but ignored
        exp_q.push_back({8'h30, 8'h11}); exp_mem[8'h30] = 8'h11;
        b_start;
        wr_byte({7'h2E, 1'b0}, ack); chk(ack, "R7 addr ack", ack, 1);
        wr_byte(8'h30, ack);         chk(ack, "R7 ptr ack", ack, 1);
        wr_byte(8'h11, ack);         chk(ack, "R7 data ack", ack, 1);
        wr_byte(8'h22, ack);         chk(ack, "R7 extra ack", ack, 1);
        wr_byte(8'h33, ack);         chk(ack, "R7 extra ack 2", ack, 1);
        b_stop;
        chk(reg_addr == 8'h30, "R7 pointer kept", reg_addr, 8'h30);
        t_read(7'h2E, 8'h11, "R7 register holds first data");

        // R10: repeated start between pointer write and read
        b_start;
        wr_byte({7'h2E, 1'b0}, ack); chk(ack, "R10 addr ack", ack, 1);
        wr_byte(8'h40, ack);         chk(ack, "R10 ptr ack", ack, 1);
        b_start;
        wr_byte({7'h2E, 1'b1}, ack); chk(ack, "R10 restart read ack", ack, 1);
        rd_byte(v);                  chk(v == exp_mem[8'h40], "R10 read after restart", v, exp_mem[8'h40]);
        b_stop;
        chk(sda_pd == 0, "R11 released after stop", sda_pd, 0);

        // R8, R9: reprogram prefix with data 0x3B -> address {01110,10} = 0x3A
        t_write(7'h2E, 8'h48, 8'h3B, 1, "R8 prefix write acks");
        t_probe(7'h2E, 0, "R8 old address dropped");
        t_probe(7'h3B, 0, "R9 data low bits ignored");
        t_probe(7'h3A, 1, "R8 new address acked");
        strap = 2'b01;
        t_probe(7'h3A, 1, "R9 strap change after reset ignored");
        t_probe(7'h39, 0, "R9 no ack for new strap value");
        t_read(7'h3A, 8'h3B, "R8 prefix register readback");

        // R13: reset restores prefix and re-captures straps (now 01 -> 0x2D)
        @(negedge clk); rst = 1;
        repeat (4) @(negedge clk); rst = 0;
        wq;
        chk(reg_addr == 8'h00, "R13 pointer cleared", reg_addr, 0);
        t_probe(7'h3A, 0, "R13 programmed address gone");
        t_probe(7'h2D, 1, "R13 default prefix with new straps");

        chk(pd_bad == 0, "R12 pull-down change with SCL high", pd_bad, 0);
        chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule